// File: doc/BRIEF.md
# Burst-Format Configuration Register Loader

This block runs once at configuration time, after a start pulse. It reads a serial configuration memory one byte at a time through a request/acknowledge port and decodes a burst-formatted image found there. The decoded image is turned into 32-bit register writes on a single-cycle write strobe. Writes can go to any register word in a 1 KB register space.

The image begins with a marker byte. A byte holding the number of bursts follows it. Each burst is an 8-bit word index, an 8-bit word count and that many big-endian 32-bit words.

Every write waits until two external interface-busy flags are both low. Every byte fetch is checked against a memory ceiling that a size strap selects. When loading ends, normally or because the ceiling was reached, the block drops busy, raises done and can give a one-cycle interrupt.

Top module: `cfg_burst_loader`

## Requirements
- R1: A start pulse is taken only when the block is idle or finished. The cycle after an accepted start, busy is high, done is low and overflow is clear. The first byte fetched is at memory offset 17. A start seen while busy has no effect on the writes or the status.
- R2: Only the marker value A5h at offset 17 lets loading continue. Any other value ends loading with no register write and no overflow.
- R3: The byte at offset 18 is the number of bursts. A value of 0 ends loading with no write.
- R4: A burst header is two bytes: the word index, then the word count. The byte address of the first write is the index shifted left by two (wr_addr = {index, 2'b00}). A count of 0 writes nothing, and decoding goes on with the next header.
- R5: Each word is built from four successive bytes, most significant first. There is exactly one write per word. Within a burst, the write address steps by 4 and wraps inside the 10-bit register space.
- R6: wr_en is never high in a cycle where csr_busy or mgmt_busy is high. A write stays pending until both are low, and each write strobe lasts one cycle.
- R7: rd_req stays high, with rd_addr steady, until rd_ack. rd_data is taken in the cycle rd_ack is high.
- R8: The memory ceiling is 2^(7+size_strap) − 1 bytes, so strap values 0..3 give 127, 255, 511 and 1023. No fetch above the ceiling is ever issued. An attempted fetch above it ends loading and sets overflow, which stays set until the next accepted start.
- R9: When loading ends, busy goes low and done goes high. Done then holds until the next accepted start.
- R10: In the first cycle of the finished state, irq pulses for one cycle if irq_en is high. It stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a load |
| size_strap | input | STRAP_W | Memory size range select |
| irq_en | input | 1 | Enables the finish interrupt |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | ADDR_W | Byte address being read |
| rd_ack | input | 1 | Read data valid this cycle |
| rd_data | input | 8 | Read byte |
| csr_busy | input | 1 | Switch register interface busy |
| mgmt_busy | input | 1 | PHY management interface busy |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 10 | Register byte address |
| wr_data | output | 32 | Register write data |
| busy | output | 1 | Load in progress |
| done | output | 1 | Finished and waiting |
| overflow | output | 1 | Ceiling reached (sticky) |
| irq | output | 1 | One-cycle finish interrupt |

## Verification
Two events can fall in the same cycle. One is a completed word becoming writable. The other is a busy flag dropping, or the final write coinciding with the move into the finished state and the interrupt.

The bench toggles both busy flags at random every cycle while words complete. It records the flags together with the write strobe at each sampling point, so a write issued under a high flag is reported.

It then checks that the interrupt arrives exactly once after the last expected write. The expected write list is rebuilt from the image by a bench-side parser.

// File: rtl/cbl_pkg.sv
// Shared types and constants of the burst-format register loader.
// Assumes: image layout fixed by the format (marker at offset 17, 8-bit word index).
package cbl_pkg;
    localparam int          MARK_OFFSET = 17;
    localparam logic [7:0]  VALID_MARK  = 8'hA5;
    localparam int          IDX_W       = 8;
    localparam int          REG_AW      = IDX_W + 2;
    localparam int          WORD_W      = 32;

    typedef enum logic [2:0] {
        S_IDLE,
        S_MARK,
        S_TOTAL,
        S_HIDX,
        S_HCNT,
        S_DATA,
        S_WGATE,
        S_FIN
    } seq_state_t;
endpackage

// File: rtl/cbl_limit.sv
// Converts the size strap into the highest readable byte address.
// Assumes: BASE_LOG2 + 2**STRAP_W - 1 <= ADDR_W.
module cbl_limit #(
    parameter int ADDR_W    = 16,
    parameter int BASE_LOG2 = 7,
    parameter int STRAP_W   = 2
) (
    input  logic [STRAP_W-1:0] size_strap,
    output logic [ADDR_W-1:0]  ceiling
);
    localparam int NSEL = 1 << STRAP_W;

    logic [ADDR_W-1:0] table_q [NSEL];

    // One constant ceiling per strap value: top address of that size range.
    for (genvar g = 0; g < NSEL; g++) begin : g_ceiling
        assign table_q[g] = ADDR_W'((64'd1 << (BASE_LOG2 + g)) - 64'd1);
    end

    assign ceiling = table_q[size_strap];
endmodule

// File: rtl/cbl_fetch.sv
// Byte fetch channel: holds a memory pointer, issues one request per wanted
// byte and flags an attempt to read past the ceiling instead of reading.
// Assumes: responder returns rd_ack only while rd_req is high.
module cbl_fetch #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              want,
    input  logic [ADDR_W-1:0] ceiling,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [7:0]        rd_data,
    output logic              byte_vld,
    output logic [7:0]        byte_val,
    output logic              past_end
);
    import cbl_pkg::*;

    logic              pending;
    logic [ADDR_W-1:0] ptr;

    assign rd_req   = pending;
    assign rd_addr  = ptr;
    assign byte_vld = pending && rd_ack;
    assign byte_val = rd_data;
    assign past_end = want && !pending && (ptr > ceiling);

    // Pointer and outstanding-request tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            ptr     <= '0;
        end else if (restart) begin
            pending <= 1'b0;
            ptr     <= ADDR_W'(MARK_OFFSET);
        end else if (pending) begin
            if (rd_ack) begin
                pending <= 1'b0;
                ptr     <= ptr + 1'b1;
            end
        end else if (want && (ptr <= ceiling)) begin
            pending <= 1'b1;
        end
    end
endmodule

// File: rtl/cbl_seq.sv
// Image decoder: walks marker, burst total, headers and data bytes, builds
// words, gates each write on the two busy flags and owns the status outputs.
// Assumes: at most one byte_vld per wanted byte; past_end only while wanting.
module cbl_seq (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       irq_en,
    input  logic                       byte_vld,
    input  logic [7:0]                 byte_val,
    input  logic                       past_end,
    input  logic                       csr_busy,
    input  logic                       mgmt_busy,
    output logic                       want,
    output logic                       restart,
    output logic                       wr_en,
    output logic [cbl_pkg::REG_AW-1:0] wr_addr,
    output logic [cbl_pkg::WORD_W-1:0] wr_data,
    output logic                       busy,
    output logic                       done,
    output logic                       overflow,
    output logic                       irq
);
    import cbl_pkg::*;

    seq_state_t         st, st_nxt;
    logic [7:0]         bursts_left;
    logic [7:0]         words_left;
    logic [IDX_W-1:0]   word_idx;
    logic [WORD_W-1:0]  word_q;
    logic [1:0]         byte_pos;
    logic               last_burst;
    logic               wr_go;

    assign last_burst = (bursts_left == 8'd1);
    assign wr_go      = (st == S_WGATE) && !csr_busy && !mgmt_busy;
    assign want       = (st == S_MARK) || (st == S_TOTAL) || (st == S_HIDX)
                     || (st == S_HCNT) || (st == S_DATA);
    assign restart    = start && ((st == S_IDLE) || (st == S_FIN));
    assign wr_en      = wr_go;
    assign wr_addr    = {word_idx, 2'b00};
    assign wr_data    = word_q;
    assign busy       = (st != S_IDLE) && (st != S_FIN);
    assign done       = (st == S_FIN);

    // Next-state decode of the image walk.
    always_comb begin
        st_nxt = st;
        case (st)
            S_IDLE, S_FIN: if (start) st_nxt = S_MARK;
            S_MARK:  if (byte_vld) st_nxt = (byte_val == VALID_MARK) ? S_TOTAL : S_FIN;
            S_TOTAL: if (byte_vld) st_nxt = (byte_val == 8'd0) ? S_FIN : S_HIDX;
            S_HIDX:  if (byte_vld) st_nxt = S_HCNT;
            S_HCNT:  if (byte_vld) begin
                         if (byte_val != 8'd0) st_nxt = S_DATA;
                         else                  st_nxt = last_burst ? S_FIN : S_HIDX;
                     end
            S_DATA:  if (byte_vld && (byte_pos == 2'd3)) st_nxt = S_WGATE;
            S_WGATE: if (wr_go) begin
                         if (words_left == 8'd1) st_nxt = last_burst ? S_FIN : S_HIDX;
                         else                    st_nxt = S_DATA;
                     end
            default: st_nxt = S_IDLE;
        endcase
        if (past_end) st_nxt = S_FIN;
    end

    // State, status flags and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            overflow <= 1'b0;
            irq      <= 1'b0;
        end else begin
            st  <= st_nxt;
            irq <= irq_en && (st_nxt == S_FIN) && (st != S_FIN);
            if (restart)       overflow <= 1'b0;
            else if (past_end) overflow <= 1'b1;
        end
    end

    // Burst counters, word index and word assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bursts_left <= '0;
            words_left  <= '0;
            word_idx    <= '0;
            word_q      <= '0;
            byte_pos    <= '0;
        end else begin
            case (st)
                S_TOTAL: if (byte_vld) bursts_left <= byte_val;
                S_HIDX:  if (byte_vld) word_idx <= byte_val;
                S_HCNT:  if (byte_vld) begin
                             words_left <= byte_val;
                             byte_pos   <= 2'd0;
                             if (byte_val == 8'd0) bursts_left <= bursts_left - 1'b1;
                         end
                S_DATA:  if (byte_vld) begin
                             word_q   <= {word_q[WORD_W-9:0], byte_val};
                             byte_pos <= byte_pos + 1'b1;
                         end
                S_WGATE: if (wr_go) begin
                             word_idx   <= word_idx + 1'b1;
                             words_left <= words_left - 1'b1;
                             if (words_left == 8'd1) bursts_left <= bursts_left - 1'b1;
                         end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cfg_burst_loader.sv
// Top of the burst-format register loader: strap ceiling, byte fetch channel
// and image decoder. Assumes size_strap is steady while a load runs.
module cfg_burst_loader #(
    parameter int ADDR_W    = 16,
    parameter int BASE_LOG2 = 7,
    parameter int STRAP_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [STRAP_W-1:0] size_strap,
    input  logic               irq_en,
    output logic               rd_req,
    output logic [ADDR_W-1:0]  rd_addr,
    input  logic               rd_ack,
    input  logic [7:0]         rd_data,
    input  logic               csr_busy,
    input  logic               mgmt_busy,
    output logic               wr_en,
    output logic [9:0]         wr_addr,
    output logic [31:0]        wr_data,
    output logic               busy,
    output logic               done,
    output logic               overflow,
    output logic               irq
);
    logic [ADDR_W-1:0] ceiling;
    logic              want, restart, byte_vld, past_end;
    logic [7:0]        byte_val;

    cbl_limit #(.ADDR_W(ADDR_W), .BASE_LOG2(BASE_LOG2), .STRAP_W(STRAP_W)) u_limit (
        .size_strap (size_strap),
        .ceiling    (ceiling)
    );

    cbl_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .want     (want),
        .ceiling  (ceiling),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .rd_ack   (rd_ack),
        .rd_data  (rd_data),
        .byte_vld (byte_vld),
        .byte_val (byte_val),
        .past_end (past_end)
    );

    cbl_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .irq_en    (irq_en),
        .byte_vld  (byte_vld),
        .byte_val  (byte_val),
        .past_end  (past_end),
        .csr_busy  (csr_busy),
        .mgmt_busy (mgmt_busy),
        .want      (want),
        .restart   (restart),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .busy      (busy),
        .done      (done),
        .overflow  (overflow),
        .irq       (irq)
    );
endmodule

// File: rtl/cbl_checker.sv
// Temporal checks on the loader's ports, attached to every instance by bind.
// Assumes size_strap is steady while a load runs.
module cbl_checker #(
    parameter int ADDR_W    = 16,
    parameter int BASE_LOG2 = 7,
    parameter int STRAP_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [STRAP_W-1:0] size_strap,
    input logic               rd_req,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic               rd_ack,
    input logic               wr_en,
    input logic               busy,
    input logic               done,
    input logic               overflow,
    input logic               irq
);
    logic [ADDR_W:0] top_addr;

    // Independent ceiling from the strap.
    assign top_addr = ((ADDR_W+1)'(1) << (BASE_LOG2 + 32'(size_strap))) - 1'b1;

    assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy && !overflow);
    assert_read_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req && $stable(rd_addr));
    assert_read_ceiling_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> ({1'b0, rd_addr} <= top_addr));
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !start |=> overflow);
    assert_write_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
    assert_busy_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);
    assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done);
    assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    assert_irq_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);
endmodule

bind cfg_burst_loader cbl_checker #(
    .ADDR_W(ADDR_W), .BASE_LOG2(BASE_LOG2), .STRAP_W(STRAP_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .size_strap (size_strap),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_ack     (rd_ack),
    .wr_en      (wr_en),
    .busy       (busy),
    .done       (done),
    .overflow   (overflow),
    .irq        (irq)
);

// File: tb/sim_cfg_burst_loader.sv
// Bench: memory responder with random latency, random busy flags, directed
// images plus random images; expected writes come from a bench-side parser.
module sim_cfg_burst_loader;
    localparam int CLK_PERIOD = 10;
    localparam int MEMSZ      = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  size_strap = 2'd0;
    logic        irq_en = 1'b0;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic        rd_ack = 1'b0;
    logic [7:0]  rd_data = 8'h00;
    logic        csr_busy = 1'b0;
    logic        mgmt_busy = 1'b0;
    logic        wr_en;
    logic [9:0]  wr_addr;
    logic [31:0] wr_data;
    logic        busy, done, overflow, irq;

    cfg_burst_loader u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .size_strap(size_strap),
        .irq_en(irq_en), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
        .rd_data(rd_data), .csr_busy(csr_busy), .mgmt_busy(mgmt_busy),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy),
        .done(done), .overflow(overflow), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0]  mem [MEMSZ];
    logic [9:0]  e_a [512];
    logic [31:0] e_d [512];
    logic [9:0]  a_a [512];
    logic [31:0] a_d [512];
    int e_n, a_n, irq_n, gate_bad, max_rd, first_rd, reads, wp;
    bit e_ovf, busy_rand;
    int total = 0, fails = 0;
    int lat = 0;

    task automatic chk(string req, bit ok, longint act, longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Bench parser: expected writes and overflow for a given ceiling.
    task automatic build_expect(int lim);
        int p = 17;
        int nb, cnt;
        logic [7:0] idx;
        logic [31:0] w;
        e_n = 0; e_ovf = 0;
        if (p > lim) begin e_ovf = 1; return; end
        if (mem[p] != 8'hA5) return;
        p++;
        if (p > lim) begin e_ovf = 1; return; end
        nb = mem[p]; p++;
        for (int b = 0; b < nb; b++) begin
            if (p > lim) begin e_ovf = 1; return; end
            idx = mem[p]; p++;
            if (p > lim) begin e_ovf = 1; return; end
            cnt = mem[p]; p++;
            for (int k = 0; k < cnt; k++) begin
                w = 0;
                for (int j = 0; j < 4; j++) begin
                    if (p > lim) begin e_ovf = 1; return; end
                    w = {w[23:0], mem[p]}; p++;
                end
                e_a[e_n] = {idx, 2'b00}; e_d[e_n] = w; e_n++;
                idx = idx + 8'd1;
            end
        end
    endtask

    task automatic put(logic [7:0] v);
        mem[wp % MEMSZ] = v; wp++;
    endtask

    task automatic fill_noise();
        for (int i = 0; i < MEMSZ; i++) mem[i] = 8'($urandom);
        wp = 17;
    endtask

    // Input driver: responder and busy flags, changed just after each edge.
    initial forever begin
        @(posedge clk); #1;
        if (rd_ack) rd_ack = 1'b0;
        else if (rd_req) begin
            if (lat == 0) begin
                rd_ack = 1'b1;
                rd_data = mem[int'(rd_addr) % MEMSZ];
                reads++;
                if (reads == 1) first_rd = int'(rd_addr);
                if (int'(rd_addr) > max_rd) max_rd = int'(rd_addr);
                lat = $urandom % 3;
            end else lat--;
        end
        csr_busy  = busy_rand && ($urandom % 3 == 0);
        mgmt_busy = busy_rand && ($urandom % 3 == 0);
    end

    // Output monitor, away from the active edge.
    initial forever begin
        @(negedge clk);
        if (wr_en) begin
            if (a_n < 512) begin a_a[a_n] = wr_addr; a_d[a_n] = wr_data; end
            a_n++;
            if (csr_busy || mgmt_busy) gate_bad++;
        end
        if (irq) irq_n++;
    end

    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic run_case(string name, int strap, bit ien, bit stray);
        int lim = (1 << (7 + strap)) - 1;
        int cyc = 0;
        int bad = -1;
        build_expect(lim);
        size_strap = 2'(strap); irq_en = ien;
        a_n = 0; irq_n = 0; gate_bad = 0; max_rd = 0; first_rd = -1; reads = 0;
        pulse_start();
        chk({name, " R1 busy after start"}, busy && !done && !overflow, {busy, done, overflow}, 3'b100);
        if (stray) begin
            repeat (6) @(posedge clk);
            #1;
            if (busy) begin start = 1'b1; @(posedge clk); #1 start = 1'b0; end
        end
        while (!done && cyc < 60000) begin @(posedge clk); #1; cyc++; end
        repeat (3) @(posedge clk);
        #1;
        chk({name, " R9 finished"}, done && !busy, {done, busy}, 2'b10);
        chk({name, " R1 first fetch at 17"}, first_rd == 17, first_rd, 17);
        chk({name, " R5 write count"}, a_n == e_n, a_n, e_n);
        for (int i = 0; i < e_n && i < a_n; i++)
            if (bad < 0 && (a_a[i] != e_a[i] || a_d[i] != e_d[i])) bad = i;
        chk({name, " R4 R5 write address/data"}, bad < 0,
            (bad < 0) ? 0 : {a_a[bad], a_d[bad]}, (bad < 0) ? 0 : {e_a[bad], e_d[bad]});
        chk({name, " R8 overflow flag"}, overflow == e_ovf, overflow, e_ovf);
        chk({name, " R8 no fetch above ceiling"}, max_rd <= lim, max_rd, lim);
        chk({name, " R6 no write under busy"}, gate_bad == 0, gate_bad, 0);
        chk({name, " R10 irq count"}, irq_n == int'(ien), irq_n, ien);
    endtask

    initial begin
        void'($urandom(32'h5EED1234));
        busy_rand = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset idle", !busy && !done && !overflow && !irq, {busy, done, overflow, irq}, 0);
        chk("R7 reset no request", !rd_req && !wr_en, {rd_req, wr_en}, 0);

        // Three-burst example image.
        busy_rand = 1;
        fill_noise();
        put(8'hA5); put(8'd3);
        put(8'h10); put(8'd1);
        for (int i = 1; i <= 4; i++) put(8'h10 + 8'(i));
        put(8'h20); put(8'd2);
        for (int i = 1; i <= 8; i++) put(8'h20 + 8'(i));
        put(8'h30); put(8'd3);
        for (int i = 1; i <= 12; i++) put(8'h30 + 8'(i));
        run_case("example", 0, 1, 0);
        chk("R4 example first address 40h", a_a[0] == 10'h040 && a_d[0] == 32'h11121314, {a_a[0], a_d[0]}, {10'h040, 32'h11121314});
        chk("R5 example last address C8h", a_a[5] == 10'h0C8 && a_d[5] == 32'h393A3B3C, {a_a[5], a_d[5]}, {10'h0C8, 32'h393A3B3C});

        // Example again with interrupt off and a stray start mid-load.
        run_case("irq off", 0, 0, 0);
        run_case("stray start R1", 1, 1, 1);

        // Wrong marker.
        fill_noise(); put(8'h5A); put(8'd2);
        run_case("bad marker R2", 0, 1, 0);
        chk("R2 single fetch", reads == 1, reads, 1);

        // Zero bursts.
        fill_noise(); put(8'hA5); put(8'd0);
        run_case("zero total R3", 0, 1, 0);
        chk("R3 two fetches", reads == 2, reads, 2);

        // Empty burst, then index wrap at the top of the register space.
        fill_noise(); put(8'hA5); put(8'd2);
        put(8'h08); put(8'd0);
        put(8'hFF); put(8'd2);
        for (int i = 0; i < 8; i++) put(8'hC0 + 8'(i));
        run_case("empty+wrap", 0, 1, 0);
        chk("R4 empty burst skipped, wrap to 000h", a_n == 2 && a_a[1] == 10'h000, {a_n, a_a[1]}, {2, 10'h000});

        // Ceiling reached inside a long burst.
        fill_noise(); put(8'hA5); put(8'd1); put(8'h04); put(8'd40);
        run_case("overflow R8", 0, 1, 0);
        chk("R8 overflow set", overflow == 1'b1, overflow, 1);

        // Random images over all straps.
        for (int t = 0; t < 24; t++) begin
            int nb = $urandom % 6;
            fill_noise();
            put(($urandom % 8 == 0) ? 8'h3C : 8'hA5);
            put(8'(nb));
            for (int b = 0; b < nb; b++) begin
                int c = ($urandom % 5 == 0) ? 0 : 1 + $urandom % 12;
                if (t % 6 == 5) c = 30 + $urandom % 20;
                put(8'($urandom)); put(8'(c));
                for (int k = 0; k < 4 * c; k++) put(8'($urandom));
            end
            run_case("random", $urandom % 4, 1'($urandom), 1'(t % 4 == 0));
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 190000);
        total++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule